// File: doc/BRIEF.md
# External Bus Release Arbiter

This block decides who owns a shared external local bus. Five on-chip requesters take turns on it in rotating order. An off-chip device can take the bus by pulling an active-low request line low. The arbiter answers on an active-low acknowledge line once it has let go of the bus. A mode input selects one of two ownership styles:

- **Master mode.** The arbiter keeps the bus parked on its own drivers while nothing is happening.
- **Slave mode.** The arbiter claims the bus only while an on-chip requester needs it, and hands the bus back after the last access.

Each requester raises a group-lock signal while it is inside an indivisible run of cycles, such as a split access, a 32-byte burst, or a read-then-write atomic pair. The cycle generator pulses a cycle-end input when each bus cycle finishes. The arbiter moves ownership only at a cycle end where the lock is low.

The arbiter also orders the hand-over. The cycle generator may drive control strobes active only while the strobe-enable output is high. Strobe-enable always falls before the output drivers are switched off, and it rises again only after the drivers have been re-enabled.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While reset is held, `bus_oe_o`=0, `strobe_en_o`=0, `gnt_o`=0 and `back_n_o`=1. In master mode, the first clock after reset sets `bus_oe_o`=1 with `strobe_en_o`=0, and the second clock sets `strobe_en_o`=1.
- R2: On-chip requesters are served in rotating order. Bit i of `req_i`, `lock_i` and `gnt_o` belongs to requester i. The first grant after reset goes to the lowest-numbered pending requester, counting from index 0. Each later search starts at the index just above the requester whose group finished last.
- R3: A grant stays unchanged while the granted requester's lock bit is high. The grant is dropped at the clock edge where `cyc_end_i` is high and that lock bit is low. A new grant appears no earlier than the following clock.
- R4: An off-chip request is acted on only when no grant is active, or at a group end as defined in R3. While a locked group runs, `back_n_o` stays 1 and the grant holds.
- R5: At a group end where the off-chip request is pending, it wins over every pending on-chip request. No grant is issued until the off-chip device has given the bus back.
- R6: Hand-over proceeds in three clocks:
  - first a clock with drivers on and strobes off;
  - then a clock with drivers off;
  - then `back_n_o`=0.
  With the bus idle, `back_n_o` falls at the 5th clock edge after `breq_n_i` falls, because the request first passes a two-stage synchronizer.
- R7: After `breq_n_i` rises:
  - `back_n_o` returns to 1 at the 3rd edge;
  - in master mode, drivers turn on at the 4th edge with strobes off;
  - strobes are enabled at the 5th edge.
- R8: In slave mode (`slave_mode_i`=1), when no grant is active and no requests are pending, the bus is given up through the R6 idle and driver-off clocks. `back_n_o` stays 1 and `bus_oe_o` ends at 0.
- R9: In slave mode, `breq_n_i` is ignored and `back_n_o` stays 1.
- R10: In slave mode, a pending request claims the bus: drivers come on at the 1st edge, strobes at the 2nd, and the grant at the 3rd.
- R11: `gnt_o` is at most one-hot, and is non-zero only while `strobe_en_o`=1. `strobe_en_o`=1 implies `bus_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slave_mode_i | input | 1 | 1 = slave mode, 0 = master mode |
| req_i | input | N_REQ | Bus request, one bit per on-chip requester |
| lock_i | input | N_REQ | Group-lock, high during every cycle of an indivisible group |
| cyc_end_i | input | 1 | One-clock pulse at the end of each bus cycle |
| breq_n_i | input | 1 | Off-chip bus request, active low, asynchronous |
| back_n_o | output | 1 | Bus acknowledge to the off-chip device, active low |
| gnt_o | output | N_REQ | One-hot grant to an on-chip requester |
| strobe_en_o | output | 1 | Control strobes may be driven active |
| bus_oe_o | output | 1 | Bus output drivers enabled |

## Verification
Each result has a fixed latency:
- A change on `breq_n_i` crosses two synchronizer flops and then one state register. The first effect therefore shows at the 3rd edge, and the acknowledge appears at the 5th.
- A group end or a mode change takes effect at the next edge.
- A new grant follows one clock after the previous grant is dropped.

The bench drives inputs on the falling edge. It counts rising edges before sampling, on a falling edge, exactly at the edge where each result is due. At several points it also samples the edges just before and after, to confirm that nothing moves early or late.

// File: rtl/ebr_pkg.sv
package ebr_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_PREP  = 3'd1,
        ST_OWN   = 3'd2,
        ST_QUIET = 3'd3,
        ST_TRI   = 3'd4,
        ST_YIELD = 3'd5
    } hand_st_e;

endpackage

// File: rtl/ebr_sync.sv
module ebr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ebr_rr_pick.sv
module ebr_rr_pick #(
    parameter int N     = 5,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [IW-1:0] last_i,
    output logic          any_o,
    output logic [N-1:0]  pick_oh_o
);
    always_comb begin
        logic found;
        found     = 1'b0;
        pick_oh_o = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(last_i) + 1 + k) % N;
            if (!found && req_i[idx]) begin
                pick_oh_o[idx] = 1'b1;
                found          = 1'b1;
            end
        end
        any_o = found;
    end
endmodule

// File: rtl/ebr_group_end.sv
module ebr_group_end #(
    parameter int N   = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  gnt_i,
    input  logic [N-1:0]  lock_i,
    input  logic          cyc_end_i,
    output logic          done_o,
    output logic [IW-1:0] idx_o
);
    assign done_o = (|gnt_i) && cyc_end_i && !(|(gnt_i & lock_i));

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
    import ebr_pkg::*;
#(
    parameter int N_REQ       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slave_mode_i,
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] lock_i,
    input  logic             cyc_end_i,
    input  logic             breq_n_i,
    output logic             back_n_o,
    output logic [N_REQ-1:0] gnt_o,
    output logic             strobe_en_o,
    output logic             bus_oe_o
);
    localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    typedef struct packed {
        hand_st_e         st;
        logic [N_REQ-1:0] gnt;
        logic [IDX_W-1:0] last;
        logic             ext;
    } regs_t;

    regs_t r_q, r_d;

    logic             breq_n_s;
    logic             breq_act;
    logic             any_req;
    logic [N_REQ-1:0] pick_oh;
    logic             grp_done;
    logic [IDX_W-1:0] gnt_idx;

    ebr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (breq_n_i),
        .q_o   (breq_n_s)
    );

    ebr_rr_pick #(.N(N_REQ)) u_pick (
        .req_i     (req_i),
        .last_i    (r_q.last),
        .any_o     (any_req),
        .pick_oh_o (pick_oh)
    );

    ebr_group_end #(.N(N_REQ)) u_gend (
        .gnt_i     (r_q.gnt),
        .lock_i    (lock_i),
        .cyc_end_i (cyc_end_i),
        .done_o    (grp_done),
        .idx_o     (gnt_idx)
    );

    // off-chip request counts only in master mode
    assign breq_act = !breq_n_s && !slave_mode_i;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_OFF: begin
                if (breq_act)                        r_d.st = ST_YIELD;
                else if (!slave_mode_i || any_req)   r_d.st = ST_PREP;
            end
            ST_PREP: r_d.st = ST_OWN;
            ST_OWN: begin
                if (|r_q.gnt) begin
                    if (grp_done) begin
                        r_d.gnt  = '0;
                        r_d.last = gnt_idx;
                        if (breq_act) begin
                            r_d.st  = ST_QUIET;
                            r_d.ext = 1'b1;
                        end
                    end
                end else if (breq_act) begin
                    r_d.st  = ST_QUIET;
                    r_d.ext = 1'b1;
                end else if (any_req) begin
                    r_d.gnt = pick_oh;
                end else if (slave_mode_i) begin
                    r_d.st  = ST_QUIET;
                    r_d.ext = 1'b0;
                end
            end
            ST_QUIET: r_d.st = ST_TRI;
            ST_TRI: begin
                r_d.st  = (r_q.ext && breq_act) ? ST_YIELD : ST_OFF;
                r_d.ext = 1'b0;
            end
            ST_YIELD: begin
                if (!breq_act) r_d.st = ST_OFF;
            end
            default: r_d.st = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_OFF;
            r_q.gnt  <= '0;
            r_q.last <= IDX_W'(N_REQ - 1);
            r_q.ext  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gnt_o       = r_q.gnt;
    assign strobe_en_o = (r_q.st == ST_OWN);
    assign bus_oe_o    = (r_q.st == ST_PREP) || (r_q.st == ST_OWN) || (r_q.st == ST_QUIET);
    assign back_n_o    = (r_q.st != ST_YIELD);
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker #(
    parameter int N_REQ = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] lock_i,
    input logic [N_REQ-1:0] gnt_o,
    input logic             back_n_o,
    input logic             strobe_en_o,
    input logic             bus_oe_o
);
    a_r6_ack_only_tristated: assert property (@(posedge clk) disable iff (!rst_n)
        !back_n_o |-> !bus_oe_o);

    a_r11_strobe_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_en_o |-> bus_oe_o);

    a_r6_quiet_before_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe_o) |-> !$past(strobe_en_o));

    a_r1_oe_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_en_o) |-> $past(bus_oe_o));

    a_r6_ack_after_tristate: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(back_n_o) |-> !$past(bus_oe_o));

    a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));

    a_r11_grant_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt_o) |-> strobe_en_o);

    a_r3_lock_holds_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|(gnt_o & lock_i)) |=> $stable(gnt_o));
endmodule

bind ext_bus_arbiter ebr_checker #(.N_REQ(N_REQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_i      (lock_i),
    .gnt_o       (gnt_o),
    .back_n_o    (back_n_o),
    .strobe_en_o (strobe_en_o),
    .bus_oe_o    (bus_oe_o)
);

// File: tb/ext_bus_arbiter_bench.sv
module ext_bus_arbiter_bench;
    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         slave_mode;
    logic [N-1:0] req, lock;
    logic         cyc_end;
    logic         breq_n;
    logic         back_n;
    logic [N-1:0] gnt;
    logic         strobe_en;
    logic         bus_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ext_bus_arbiter #(.N_REQ(N), .SYNC_STAGES(2)) u_ext_bus_arbiter (
        .clk          (clk),
        .rst_n        (rst_n),
        .slave_mode_i (slave_mode),
        .req_i        (req),
        .lock_i       (lock),
        .cyc_end_i    (cyc_end),
        .breq_n_i     (breq_n),
        .back_n_o     (back_n),
        .gnt_o        (gnt),
        .strobe_en_o  (strobe_en),
        .bus_oe_o     (bus_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; slave_mode = 1'b0; req = '0; lock = '0;
        cyc_end = 1'b0; breq_n = 1'b1;
        tick(3);
        chk("R1 oe in reset", 32'(bus_oe), 0);
        chk("R1 strobe in reset", 32'(strobe_en), 0);
        chk("R1 gnt in reset", 32'(gnt), 0);
        chk("R1 back_n in reset", 32'(back_n), 1);
        rst_n = 1'b1;
        tick(1);
        chk("R1 oe first clock", 32'(bus_oe), 1);
        chk("R1 strobe off first clock", 32'(strobe_en), 0);
        tick(1);
        chk("R1 strobe second clock", 32'(strobe_en), 1);
    endtask

    task automatic t_round_robin();
        req = 5'h1F;
        tick(1);
        for (int k = 0; k < 6; k++) begin
            chk("R2 rotation grant", 32'(gnt), 32'(1 << (k % N)));
            cyc_end = 1'b1;
            tick(1);
            chk("R3 gap after group end", 32'(gnt), 0);
            cyc_end = 1'b0;
            if (k == 5) req = '0;
            tick(1);
        end
        chk("R2 no grant without requests", 32'(gnt), 0);
    endtask

    task automatic t_lock_and_priority();
        req = 5'b00100;
        tick(1);
        chk("R2 search above last", 32'(gnt), 32'h4);
        lock = 5'b00100;
        breq_n = 1'b0;
        req = 5'b01100;
        tick(4);
        for (int k = 0; k < 3; k++) begin
            cyc_end = 1'b1;
            tick(1);
            cyc_end = 1'b0;
            chk("R3 grant held under lock", 32'(gnt), 32'h4);
            chk("R4 no release under lock", 32'(back_n), 1);
            chk("R4 strobes kept under lock", 32'(strobe_en), 1);
            tick(1);
        end
        lock = '0; cyc_end = 1'b1; req = 5'b01000;
        tick(1);
        cyc_end = 1'b0;
        chk("R5 external wins, no grant", 32'(gnt), 0);
        chk("R6 idle clock drivers on", 32'(bus_oe), 1);
        chk("R6 idle clock strobes off", 32'(strobe_en), 0);
        tick(1);
        chk("R6 drivers off", 32'(bus_oe), 0);
        chk("R6 no ack yet", 32'(back_n), 1);
        tick(1);
        chk("R6 ack asserted", 32'(back_n), 0);
        tick(3);
        chk("R5 still no grant", 32'(gnt), 0);
        chk("R6 ack held", 32'(back_n), 0);
    endtask

    task automatic t_negate();
        breq_n = 1'b1;
        tick(2);
        chk("R7 ack held two edges", 32'(back_n), 0);
        tick(1);
        chk("R7 ack released", 32'(back_n), 1);
        chk("R7 drivers still off", 32'(bus_oe), 0);
        tick(1);
        chk("R7 drivers on", 32'(bus_oe), 1);
        chk("R7 strobes off on reclaim", 32'(strobe_en), 0);
        tick(1);
        chk("R7 strobes on", 32'(strobe_en), 1);
        chk("R7 no grant yet", 32'(gnt), 0);
        tick(1);
        chk("R2 pending requester 3", 32'(gnt), 32'h8);
        cyc_end = 1'b1; req = '0;
        tick(1);
        cyc_end = 1'b0;
    endtask

    task automatic t_idle_release();
        tick(2);
        breq_n = 1'b0;
        tick(2);
        chk("R6 nothing before sync", 32'(strobe_en), 1);
        tick(1);
        chk("R6 idle strobes off", 32'(strobe_en), 0);
        chk("R6 idle drivers on", 32'(bus_oe), 1);
        tick(1);
        chk("R6 idle drivers off", 32'(bus_oe), 0);
        chk("R6 idle ack not yet", 32'(back_n), 1);
        tick(1);
        chk("R6 idle ack at 5th edge", 32'(back_n), 0);
        breq_n = 1'b1;
        tick(6);
        chk("R7 back to owned", 32'(strobe_en), 1);
    endtask

    task automatic t_slave();
        slave_mode = 1'b1;
        tick(1);
        chk("R8 idle clock", 32'(bus_oe), 1);
        tick(2);
        chk("R8 drivers off", 32'(bus_oe), 0);
        chk("R8 no ack", 32'(back_n), 1);
        tick(3);
        chk("R8 stays off", 32'(bus_oe), 0);
        breq_n = 1'b0;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            chk("R9 request ignored", 32'(back_n), 1);
        end
        chk("R9 drivers untouched", 32'(bus_oe), 0);
        breq_n = 1'b1;
        tick(3);
        req = 5'b00001;
        tick(1);
        chk("R10 drivers on", 32'(bus_oe), 1);
        chk("R10 strobes off", 32'(strobe_en), 0);
        tick(1);
        chk("R10 strobes on", 32'(strobe_en), 1);
        chk("R10 no grant yet", 32'(gnt), 0);
        tick(1);
        chk("R10 grant", 32'(gnt), 32'h1);
        cyc_end = 1'b1; req = '0;
        tick(1);
        cyc_end = 1'b0;
        chk("R8 grant dropped", 32'(gnt), 0);
        tick(1);
        chk("R8 release idle clock", 32'(strobe_en), 0);
        tick(2);
        chk("R8 released after access", 32'(bus_oe), 0);
        chk("R8 no ack after access", 32'(back_n), 1);
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_lock_and_priority();
        t_negate();
        t_idle_release();
        t_slave();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule